// File: doc/BRIEF.md
# Serial IRQ slot transmitter

This block is the device end of a single shared, open-drain, active-low interrupt wire on an LPC-style bus. Internal sources deliver a 16-bit vector of active requests, one bit per IRQ number and already mapped. The block reports each active number N by pulling the wire low in one clock, at a fixed distance after the start frame. The block never drives the wire high. Outside its own pulses it only releases the wire, and the external pull-up returns it high.

In continuous mode the host opens every frame. In quiet mode the host stays silent, so the device opens a frame itself with a one-clock low pulse, which the host then stretches into a full start frame. In both modes the block then follows a frame of sixteen three-clock slots. After the last slot it waits for the host's stop frame before it accepts a new start. After reset the block stays silent until it has seen one valid start frame from the host.

Top module: `serirq_slot_tx`

## Requirements
- R1: `drive_low` is asserted only in one of two cases: the first clock (sample phase) of an IRQ slot, or a quiet-mode start pulse issued while idle.
- R2: After reset `drive_low` is 0. It stays 0 in both modes, whatever the requests are, until the first valid start frame is recognised.
- R3: A start frame is a run of 4 to 8 consecutive low samples of `line_in` followed by a high sample. Runs of 3 or fewer, or of 9 or more, start nothing.
- R4: Let E be the rising edge that samples the high ending a start frame. If bit N (1..15) of `irq_req` is 1, `drive_low` is 1 for exactly the one clock that begins 3·N edges after E, and 0 for the rest of that slot.
- R5: Bit 0 of `irq_req` is never signalled. Slot 0 (the clock just after E) never carries a pulse.
- R6: Several active bits are each signalled in their own slot within the same frame.
- R7: After slot 15 the block ignores the wire until it has sampled it low and then high once (the stop frame). A low run that ends this wait cannot start a frame, even if it is 4 to 8 clocks long.
- R8: In quiet mode (`quiet_mode`=1), when the block is idle and armed, the wire is high, and the masked request vector differs from the one captured at the previous frame start, `drive_low` pulses for exactly one clock.
- R9: No start pulse is issued while the requests are unchanged since the previous frame start, or while `quiet_mode` is 0.
- R10: A frame opened by a quiet-mode pulse and stretched by the host follows the slot timing of R4. The block's own pulse counts towards the low run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| quiet_mode | input | 1 | 1 = device opens frames, 0 = host opens every frame |
| line_in | input | 1 | Synchronised sample of the shared interrupt wire (0 = low) |
| irq_req | input | 16 | Active requests, bit N = IRQ N |
| drive_low | output | 1 | Open-drain enable: 1 pulls the wire low, 0 releases it |

## Verification
A slot counter that is off by one shows at the port within the same frame: the pulse lands one or more clocks away from 3·N after the start edge. A wrong frame-state decode shows either as a pulse during the stop wait or after an invalid low run, or as a missing pulse in a valid frame. A wrong request snapshot shows within a few idle clocks in quiet mode, as a start pulse that fires with unchanged requests or fails to fire after a change. Every frame's pulse pattern is compared bit by bit against the pattern expected from the request vector.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOTS = 2'd1,
        ST_STOP  = 2'd2
    } sq_state_e;

endpackage

// File: rtl/serirq_start_detect.sv
module serirq_start_detect #(
    parameter int MIN_LOW = 4,
    parameter int MAX_LOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic start_hit
);
    localparam int CW = $clog2(MAX_LOW + 2);
    localparam logic [CW-1:0] CAP = CW'(MAX_LOW + 1);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        if (line_in)
            run_d = '0;
        else if (run_q == CAP)
            run_d = CAP;
        else
            run_d = run_q + CW'(1);
    end

    // a high sample closes a low run of legal length
    assign start_hit = line_in && (run_q >= CW'(MIN_LOW)) && (run_q <= CW'(MAX_LOW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/serirq_slot_seq.sv
module serirq_slot_seq #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_LEN  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         run,
    output logic [$clog2(NUM_SLOTS)-1:0] slot,
    output logic [$clog2(SLOT_LEN)-1:0]  phase,
    output logic                         last
);
    localparam int SW = $clog2(NUM_SLOTS);
    localparam int PW = $clog2(SLOT_LEN);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic [PW-1:0] phase;
    } seq_t;

    seq_t s_d, s_q;
    logic phase_end;

    assign phase_end = (s_q.phase == PW'(SLOT_LEN - 1));
    assign last      = phase_end && (s_q.slot == SW'(NUM_SLOTS - 1));

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (run) begin
            if (phase_end) begin
                s_d.phase = '0;
                s_d.slot  = s_q.slot + SW'(1);
            end else begin
                s_d.phase = s_q.phase + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slot  = s_q.slot;
    assign phase = s_q.phase;
endmodule

// File: rtl/serirq_req_track.sv
module serirq_req_track #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] req,
    input  logic                 capture,
    output logic [NUM_SLOTS-1:0] req_eff,
    output logic                 pending
);
    // slot 0 carries no request: edge-type numbers start at 1
    localparam logic [NUM_SLOTS-1:0] KEEP = ~NUM_SLOTS'(1);

    logic [NUM_SLOTS-1:0] snap_d, snap_q;

    assign req_eff = req & KEEP;
    assign pending = (req_eff != snap_q);

    always_comb begin
        snap_d = snap_q;
        if (capture) snap_d = req_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end
endmodule

// File: rtl/serirq_slot_tx.sv
module serirq_slot_tx
    import serirq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_LEN  = 3,
    parameter int MIN_LOW   = 4,
    parameter int MAX_LOW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 quiet_mode,
    input  logic                 line_in,
    input  logic [NUM_SLOTS-1:0] irq_req,
    output logic                 drive_low
);
    localparam int SW = $clog2(NUM_SLOTS);
    localparam int PW = $clog2(SLOT_LEN);

    typedef struct packed {
        sq_state_e state;
        logic      armed;
        logic      saw_low;
        logic      drive;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                 start_hit;
    logic                 seq_clear, seq_run, seq_last;
    logic [SW-1:0]        cur_slot, nxt_slot;
    logic [PW-1:0]        cur_phase;
    logic                 capture, pending;
    logic [NUM_SLOTS-1:0] req_eff;
    sq_state_e            cur_state;
    logic                 armed_q;

    serirq_start_detect #(.MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)) u_det (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .start_hit(start_hit)
    );

    serirq_slot_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_LEN(SLOT_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .clear(seq_clear), .run(seq_run),
        .slot(cur_slot), .phase(cur_phase), .last(seq_last)
    );

    serirq_req_track #(.NUM_SLOTS(NUM_SLOTS)) u_trk (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .capture(capture),
        .req_eff(req_eff), .pending(pending)
    );

    assign nxt_slot = cur_slot + SW'(1);

    always_comb begin
        c_d       = c_q;
        c_d.drive = 1'b0;
        seq_clear = 1'b0;
        seq_run   = 1'b0;
        capture   = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (start_hit) begin
                    c_d.state = ST_SLOTS;
                    c_d.armed = 1'b1;
                    seq_clear = 1'b1;
                    capture   = 1'b1;
                    c_d.drive = req_eff[0];
                end else if (quiet_mode && c_q.armed && line_in && !c_q.drive && pending) begin
                    c_d.drive = 1'b1;
                end
            end
            ST_SLOTS: begin
                seq_run = 1'b1;
                if (seq_last) begin
                    c_d.state   = ST_STOP;
                    c_d.saw_low = 1'b0;
                end else if (cur_phase == PW'(SLOT_LEN - 1)) begin
                    // entering the sample phase of the next slot
                    c_d.drive = c_q.armed && req_eff[nxt_slot];
                end
            end
            ST_STOP: begin
                if (!line_in)
                    c_d.saw_low = 1'b1;
                else if (c_q.saw_low)
                    c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state   <= ST_IDLE;
            c_q.armed   <= 1'b0;
            c_q.saw_low <= 1'b0;
            c_q.drive   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign drive_low = c_q.drive;
    assign cur_state = c_q.state;
    assign armed_q   = c_q.armed;
endmodule

// File: rtl/serirq_slot_tx_chk.sv
module serirq_slot_tx_chk
    import serirq_pkg::*;
#(
    parameter int SW = 4,
    parameter int PW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          quiet_mode,
    input logic          line_in,
    input logic          drive_low,
    input sq_state_e     cur_state,
    input logic          armed_q,
    input logic [SW-1:0] cur_slot,
    input logic [PW-1:0] cur_phase
);
    // R4 / R8: every pull is a single clock
    a_r4_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |=> !drive_low);

    // R1: pulls happen only in a sample phase or an idle start pulse
    a_r1_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> ((cur_state == ST_SLOTS && cur_phase == '0) || cur_state == ST_IDLE));

    // R5: slot 0 never carries a pulse
    a_r5_no_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && cur_state == ST_SLOTS) |-> (cur_slot != '0));

    // R8 / R9: idle pulses only come from quiet mode with the wire high
    a_r8_quiet_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && cur_state == ST_IDLE) |-> ($past(quiet_mode) && $past(line_in)));

    // R2: silent until armed by a host start frame
    a_r2_unarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !drive_low);

    // R7: a frame only begins from idle, never straight out of the stop wait
    a_r7_frame_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SLOTS && cur_slot == '0 && cur_phase == '0) |-> ($past(cur_state) == ST_IDLE));
endmodule

bind serirq_slot_tx serirq_slot_tx_chk #(.SW(SW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .quiet_mode(quiet_mode), .line_in(line_in),
    .drive_low(drive_low), .cur_state(cur_state), .armed_q(armed_q),
    .cur_slot(cur_slot), .cur_phase(cur_phase)
);

// File: tb/serirq_slot_tx_test.sv
`timescale 1ns/1ps
module serirq_slot_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        quiet_mode = 1'b0;
    logic        host_low = 1'b0;
    logic [15:0] irq_req = '0;
    logic        line_in;
    logic        drive_low;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    // shared wire: low if anyone pulls
    assign line_in = ~(drive_low | host_low);

    serirq_slot_tx uut (
        .clk(clk), .rst_n(rst_n), .quiet_mode(quiet_mode), .line_in(line_in),
        .irq_req(irq_req), .drive_low(drive_low)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // host start frame of len low clocks, then release
    task automatic host_start(input int len);
        @(negedge clk);
        host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic host_stop();
        host_low = 1'b1;
        repeat (2) @(negedge clk);
        host_low = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // sample 48 clocks after the start-ending edge; compare slot pattern
    task automatic collect(input logic [15:0] req, input string tag);
        logic [47:0] obs, exp;
        for (int i = 0; i < 48; i++) begin
            @(posedge clk);
            @(negedge clk);
            obs[i] = drive_low;
            exp[i] = (i % 3 == 0) && (i / 3 >= 1) && req[i / 3];
        end
        check(tag, 64'(obs), 64'(exp));
    endtask

    task automatic watch_silent(input int n, input string tag);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (drive_low) hits++;
        end
        check(tag, 64'(hits), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R2 reset value", 64'(drive_low), 64'd0);
    endtask

    task automatic t_unarmed();
        quiet_mode = 1'b1;
        irq_req    = 16'h0004;
        watch_silent(30, "R2 silent before first start (quiet)");
        quiet_mode = 1'b0;
        watch_silent(10, "R2 silent before first start (continuous)");
    endtask

    task automatic t_first_frame();
        host_start(4);
        collect(16'h0004, "R4 first frame IRQ2");
        host_stop();
    endtask

    task automatic t_patterns();
        irq_req = 16'h8000;
        host_start(6);
        collect(16'h8000, "R4 IRQ15 last slot");
        host_stop();
        irq_req = 16'hFFFF;
        host_start(8);
        collect(16'hFFFE, "R5 bit 0 never sent, all others");
        host_stop();
        irq_req = 16'h5A5B;
        host_start(5);
        collect(16'h5A5A, "R6 mixed pattern");
        host_stop();
    endtask

    task automatic t_bad_starts();
        irq_req = 16'h8002;
        host_start(3);
        watch_silent(60, "R3 3-clock low ignored");
        host_start(9);
        watch_silent(60, "R3 9-clock low ignored");
    endtask

    task automatic t_stop_guard();
        host_start(5);
        collect(16'h8002, "R4 frame before stop test");
        // stop frame that looks like a start: must not open a frame
        host_low = 1'b1;
        repeat (5) @(negedge clk);
        host_low = 1'b0;
        watch_silent(55, "R7 stop-wait low run starts nothing");
        host_start(4);
        collect(16'h8002, "R7 rearmed after stop");
        host_stop();
    endtask

    task automatic t_quiet();
        bit seen = 1'b0;
        @(negedge clk);
        irq_req    = 16'h0010;
        quiet_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (drive_low) begin
                seen = 1'b1;
                break;
            end
        end
        check("R8 quiet start pulse issued", 64'(seen), 64'd1);
        host_low = 1'b1;        // host stretches the start frame
        @(negedge clk);
        check("R8 start pulse lasts one clock", 64'(drive_low), 64'd0);
        repeat (4) @(negedge clk);
        host_low = 1'b0;
        collect(16'h0010, "R10 quiet frame IRQ4");
        host_stop();
    endtask

    task automatic t_no_change();
        watch_silent(40, "R9 unchanged requests, no pulse");
        quiet_mode = 1'b0;
        irq_req    = 16'h0100;
        watch_silent(40, "R9 continuous mode, no start pulse");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unarmed();
        t_first_frame();
        t_patterns();
        t_bad_starts();
        t_stop_guard();
        t_quiet();
        t_no_change();
        summary();
        $finish;
    end
endmodule